// File: doc/BRIEF.md
# Multidrop Address Wake Controller

This block sits between a serial receiver and its receive FIFO on a 9-bit multidrop line. On such a line the bit that would normally hold parity carries an address/data flag instead. When a character completes, the controller decides two things: whether the character goes into the FIFO, and whether the receiver is awake for the data that follows. The inputs are the received byte, its address/data bit, a station address and a two-bit wake mode.

The receiver is either asleep or listening. In host mode only software commands move it between the two. Address characters still reach the FIFO while it sleeps, so the host can inspect them. In the automatic modes, an address character can wake the receiver when it matches the station address (wake) or put it to sleep when it does not (doze). A separate load enable decides whether such an address character is kept. Host enable and disable commands are held as a pending request and take effect at the next character boundary.

The controller also holds one register bit that forces the address/data value of outgoing characters.

Top module: `mdrop_wake_ctrl`

States and transitions: `ST_SLEEP` (receiver disabled) and `ST_LISTEN` (receiver enabled). The transitions are:
- **host enable**: a pending enable applied at a boundary, `ST_SLEEP` to `ST_LISTEN`.
- **host disable**: a pending disable applied at a boundary, `ST_LISTEN` to `ST_SLEEP`.
- **auto wake**: a matching address in wake modes, `ST_SLEEP` to `ST_LISTEN`.
- **auto doze**: a non-matching address in doze modes, `ST_LISTEN` to `ST_SLEEP`.

## Requirements
- R1: After reset the receiver is disabled (`rx_enabled_o`=0), `push_o`=0, `tx_ad_o`=0 and no host command is pending.
- R2: An A/D bit of 1 marks an address character and 0 marks a data character. A pushed character presents its byte on `push_data_o` and its A/D bit on `push_ad_o`, the parity-error slot. Its framing and overrun flags appear on `push_fe_o` and `push_ovr_o`.
- R3: In mode 2'b00 (host), every address character is pushed whether the receiver is enabled or not, and address characters never change the enable state.
- R4: In every mode a data character is pushed only if the effective enable is 1. The effective enable is the pending host command if one exists, otherwise the current state. A data character that is not pushed leaves the FIFO untouched.
- R5: In mode 2'b01 (wake), an address character equal to `station_addr_i` leaves the receiver enabled. A non-matching address leaves the enable state unchanged.
- R6: In mode 2'b10 (doze), an address character different from `station_addr_i` leaves the receiver disabled. A matching address leaves the enable state unchanged.
- R7: In mode 2'b11, both the R5 and R6 rules apply.
- R8: In modes other than 2'b00, an address character is pushed exactly when `addr_load_i` is 1.
- R9: Host commands are pulses that become pending and are applied at the next character boundary. A command in the same cycle as `chr_valid_i` waits for the following character. Disable wins over a simultaneous enable, and a later command replaces an earlier pending one. The applied command holds until an address character acts on the state.
- R10: A break character (`chr_brk_i`=1) is always pushed with `push_brk_o`=1. Apart from applying a pending command, it does not change the enable state.
- R11: `push_o`, the pushed fields and `rx_enabled_o` are registered and change one cycle after `chr_valid_i`. `push_o` is high for exactly one cycle per pushed character.
- R12: A pulse on `tx_ad_wr_i` loads `tx_ad_val_i` into `tx_ad_o`, which holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chr_valid_i | input | 1 | Character-complete strobe |
| chr_data_i | input | DW | Received byte |
| chr_ad_i | input | 1 | Received address/data bit |
| chr_fe_i | input | 1 | Framing error of the character |
| chr_ovr_i | input | 1 | Overrun flag with the character |
| chr_brk_i | input | 1 | Character is a break |
| station_addr_i | input | DW | Station address |
| wake_mode_i | input | 2 | 00 host, 01 wake, 10 doze, 11 both |
| addr_load_i | input | 1 | Keep address characters in automatic modes |
| host_on_i | input | 1 | Host enable command pulse |
| host_off_i | input | 1 | Host disable command pulse |
| tx_ad_wr_i | input | 1 | Write strobe for transmit A/D bit |
| tx_ad_val_i | input | 1 | Value for transmit A/D bit |
| push_o | output | 1 | FIFO push strobe |
| push_data_o | output | DW | Byte to push |
| push_ad_o | output | 1 | A/D bit for the parity-error slot |
| push_fe_o | output | 1 | Framing flag to push |
| push_ovr_o | output | 1 | Overrun flag to push |
| push_brk_o | output | 1 | Break flag to push |
| rx_enabled_o | output | 1 | Receiver enabled |
| tx_ad_o | output | 1 | Forced A/D value for transmit |

## Verification
A host command and a character boundary can land in the same cycle. This pits the pending-command latch against the state update. The bench provokes it by pulsing `host_on_i` or `host_off_i` while `chr_valid_i` is high. It judges that the character in that cycle is handled under the old enable, and that the next character is handled under the commanded one. Enable and disable in the same cycle, and two commands back to back, check which pending command survives.

// File: rtl/mdw_pkg.sv
package mdw_pkg;
    typedef enum logic {
        ST_SLEEP  = 1'b0,
        ST_LISTEN = 1'b1
    } rx_state_e;

    localparam logic [1:0] WM_HOST = 2'b00;
endpackage

// File: rtl/mdw_addr_match.sv
module mdw_addr_match #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data_i,
    input  logic [DW-1:0] station_i,
    output logic          hit_o
);
    logic [DW-1:0] bit_eq;

    for (genvar g = 0; g < DW; g++) begin : g_bit
        assign bit_eq[g] = ~(data_i[g] ^ station_i[g]);
    end

    assign hit_o = &bit_eq;
endmodule

// File: rtl/mdw_cmd_latch.sv
module mdw_cmd_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic host_on_i,
    input  logic host_off_i,
    input  logic boundary_i,
    output logic pend_valid_o,
    output logic pend_on_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid_o <= 1'b0;
            pend_on_o    <= 1'b0;
        end else if (host_on_i || host_off_i) begin
            pend_valid_o <= 1'b1;
            pend_on_o    <= ~host_off_i;
        end else if (boundary_i) begin
            pend_valid_o <= 1'b0;
        end
    end

    // R9
    dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_off_i |=> (pend_valid_o && !pend_on_o));

    // R9
    on_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_on_i && !host_off_i) |=> (pend_valid_o && pend_on_o));
endmodule

// File: rtl/mdw_fsm.sv
module mdw_fsm
    import mdw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chr_valid_i,
    input  logic       chr_ad_i,
    input  logic       chr_brk_i,
    input  logic       hit_i,
    input  logic [1:0] mode_i,
    input  logic       addr_load_i,
    input  logic       pend_valid_i,
    input  logic       pend_on_i,
    output logic       listen_o,
    output logic       eff_on_o,
    output logic       push_req_o
);
    rx_state_e state_q, state_d;
    logic      is_addr;
    logic      wake_hit;
    logic      doze_hit;

    assign is_addr  = chr_ad_i & ~chr_brk_i;
    assign wake_hit = is_addr & mode_i[0] & hit_i;
    assign doze_hit = is_addr & mode_i[1] & ~hit_i;
    assign eff_on_o = pend_valid_i ? pend_on_i : (state_q == ST_LISTEN);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SLEEP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (chr_valid_i) begin
            unique case (state_q)
                ST_SLEEP:  if (wake_hit || (!doze_hit && eff_on_o)) state_d = ST_LISTEN;
                ST_LISTEN: if (doze_hit || (!wake_hit && !eff_on_o)) state_d = ST_SLEEP;
                default:   state_d = ST_SLEEP;
            endcase
        end
    end

    always_comb begin
        push_req_o = 1'b0;
        if (chr_valid_i) begin
            if (chr_brk_i)    push_req_o = 1'b1;
            else if (is_addr) push_req_o = (mode_i == WM_HOST) || addr_load_i;
            else              push_req_o = eff_on_o;
        end
    end

    assign listen_o = (state_q == ST_LISTEN);

    // R5
    wake_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid_i && chr_ad_i && !chr_brk_i && mode_i[0] && hit_i) |=> listen_o);

    // R6
    doze_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid_i && chr_ad_i && !chr_brk_i && mode_i[1] && !hit_i) |=> !listen_o);

    // R3
    host_addr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid_i && chr_ad_i && !chr_brk_i && mode_i == WM_HOST && !pend_valid_i)
        |=> $stable(listen_o));

    // R11
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chr_valid_i |=> $stable(listen_o));
endmodule

// File: rtl/mdrop_wake_ctrl.sv
module mdrop_wake_ctrl #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chr_valid_i,
    input  logic [DW-1:0] chr_data_i,
    input  logic          chr_ad_i,
    input  logic          chr_fe_i,
    input  logic          chr_ovr_i,
    input  logic          chr_brk_i,
    input  logic [DW-1:0] station_addr_i,
    input  logic [1:0]    wake_mode_i,
    input  logic          addr_load_i,
    input  logic          host_on_i,
    input  logic          host_off_i,
    input  logic          tx_ad_wr_i,
    input  logic          tx_ad_val_i,
    output logic          push_o,
    output logic [DW-1:0] push_data_o,
    output logic          push_ad_o,
    output logic          push_fe_o,
    output logic          push_ovr_o,
    output logic          push_brk_o,
    output logic          rx_enabled_o,
    output logic          tx_ad_o
);
    logic hit;
    logic pend_valid;
    logic pend_on;
    logic eff_on;
    logic push_req;

    mdw_addr_match #(.DW(DW)) u_match (
        .data_i    (chr_data_i),
        .station_i (station_addr_i),
        .hit_o     (hit)
    );

    mdw_cmd_latch u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_on_i    (host_on_i),
        .host_off_i   (host_off_i),
        .boundary_i   (chr_valid_i),
        .pend_valid_o (pend_valid),
        .pend_on_o    (pend_on)
    );

    mdw_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .chr_valid_i  (chr_valid_i),
        .chr_ad_i     (chr_ad_i),
        .chr_brk_i    (chr_brk_i),
        .hit_i        (hit),
        .mode_i       (wake_mode_i),
        .addr_load_i  (addr_load_i),
        .pend_valid_i (pend_valid),
        .pend_on_i    (pend_on),
        .listen_o     (rx_enabled_o),
        .eff_on_o     (eff_on),
        .push_req_o   (push_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_o      <= 1'b0;
            push_data_o <= '0;
            push_ad_o   <= 1'b0;
            push_fe_o   <= 1'b0;
            push_ovr_o  <= 1'b0;
            push_brk_o  <= 1'b0;
        end else begin
            push_o <= push_req;
            if (push_req) begin
                push_data_o <= chr_data_i;
                push_ad_o   <= chr_ad_i;
                push_fe_o   <= chr_fe_i;
                push_ovr_o  <= chr_ovr_i;
                push_brk_o  <= chr_brk_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          tx_ad_o <= 1'b0;
        else if (tx_ad_wr_i) tx_ad_o <= tx_ad_val_i;
    end

    // R11
    push_follows_chr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> $past(chr_valid_i));

    // R4
    data_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid_i && !chr_ad_i && !chr_brk_i && !eff_on) |=> !push_o);

    // R10
    brk_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid_i && chr_brk_i) |=> (push_o && push_brk_o));

    // R3
    host_addr_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid_i && chr_ad_i && !chr_brk_i && wake_mode_i == 2'b00) |=> (push_o && push_ad_o));

    // R12
    tx_ad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ad_wr_i |=> $stable(tx_ad_o));
endmodule

// File: tb/test_mdrop_wake_ctrl.sv
module test_mdrop_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chr_valid = 1'b0;
    logic [7:0] chr_data = '0;
    logic       chr_ad = 1'b0, chr_fe = 1'b0, chr_ovr = 1'b0, chr_brk = 1'b0;
    logic [7:0] station = 8'h5A;
    logic [1:0] mode = 2'b00;
    logic       addr_load = 1'b0, host_on = 1'b0, host_off = 1'b0;
    logic       tx_wr = 1'b0, tx_val = 1'b0;
    logic       push, push_ad, push_fe, push_ovr, push_brk, rx_en, tx_ad;
    logic [7:0] push_data;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mdrop_wake_ctrl #(.DW(8)) i_mdrop_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .chr_valid_i(chr_valid), .chr_data_i(chr_data),
        .chr_ad_i(chr_ad), .chr_fe_i(chr_fe), .chr_ovr_i(chr_ovr), .chr_brk_i(chr_brk),
        .station_addr_i(station), .wake_mode_i(mode), .addr_load_i(addr_load),
        .host_on_i(host_on), .host_off_i(host_off), .tx_ad_wr_i(tx_wr), .tx_ad_val_i(tx_val),
        .push_o(push), .push_data_o(push_data), .push_ad_o(push_ad), .push_fe_o(push_fe),
        .push_ovr_o(push_ovr), .push_brk_o(push_brk), .rx_enabled_o(rx_en), .tx_ad_o(tx_ad)
    );

    // {mode, load, ad, brk, cmd(0 none,1 on,2 off), data, exp_push, exp_en}
    localparam int NV = 18;
    localparam logic [16:0] VEC [NV] = '{
        {2'b00, 1'b0, 1'b0, 1'b0, 2'd0, 8'h11, 1'b0, 1'b0},
        {2'b00, 1'b0, 1'b1, 1'b0, 2'd0, 8'h33, 1'b1, 1'b0},
        {2'b00, 1'b0, 1'b0, 1'b0, 2'd1, 8'h44, 1'b1, 1'b1},
        {2'b00, 1'b0, 1'b1, 1'b0, 2'd0, 8'h77, 1'b1, 1'b1},
        {2'b00, 1'b0, 1'b0, 1'b0, 2'd2, 8'h55, 1'b0, 1'b0},
        {2'b01, 1'b0, 1'b1, 1'b0, 2'd0, 8'h5A, 1'b0, 1'b1},
        {2'b01, 1'b0, 1'b0, 1'b0, 2'd0, 8'h12, 1'b1, 1'b1},
        {2'b01, 1'b0, 1'b1, 1'b0, 2'd0, 8'h66, 1'b0, 1'b1},
        {2'b10, 1'b1, 1'b1, 1'b0, 2'd0, 8'h5A, 1'b1, 1'b1},
        {2'b10, 1'b1, 1'b1, 1'b0, 2'd0, 8'h66, 1'b1, 1'b0},
        {2'b10, 1'b0, 1'b0, 1'b0, 2'd0, 8'h21, 1'b0, 1'b0},
        {2'b10, 1'b0, 1'b1, 1'b0, 2'd0, 8'h5A, 1'b0, 1'b0},
        {2'b11, 1'b1, 1'b1, 1'b0, 2'd0, 8'h5A, 1'b1, 1'b1},
        {2'b11, 1'b0, 1'b1, 1'b0, 2'd0, 8'h99, 1'b0, 1'b0},
        {2'b11, 1'b0, 1'b0, 1'b0, 2'd1, 8'h3C, 1'b1, 1'b1},
        {2'b11, 1'b0, 1'b0, 1'b1, 2'd0, 8'h00, 1'b1, 1'b1},
        {2'b11, 1'b0, 1'b0, 1'b1, 2'd2, 8'h00, 1'b1, 1'b0},
        {2'b01, 1'b0, 1'b0, 1'b0, 2'd0, 8'h70, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_cmd(input logic [1:0] cmd);
        @(negedge clk);
        host_on  = (cmd == 2'd1);
        host_off = (cmd == 2'd2);
        @(posedge clk); #1;
        host_on = 1'b0; host_off = 1'b0;
    endtask

    task automatic send(input logic ad, input logic brk, input logic [7:0] d,
                        input logic fe, input logic ovr);
        @(negedge clk);
        chr_valid = 1'b1; chr_ad = ad; chr_brk = brk; chr_data = d;
        chr_fe = fe; chr_ovr = ovr;
        @(posedge clk); #1;
        chr_valid = 1'b0; chr_fe = 1'b0; chr_ovr = 1'b0; chr_brk = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 rx_en", {7'd0, rx_en}, 8'd0);
        chk("R1 push", {7'd0, push}, 8'd0);
        chk("R1 tx_ad", {7'd0, tx_ad}, 8'd0);
        @(negedge clk); rst_n = 1'b1;
        // R1: no pending command, data char dropped
        send(1'b0, 1'b0, 8'hA1, 1'b0, 1'b0);
        chk("R1 no pending", {7'd0, push}, 8'd0);

        // vector walk: R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            logic [16:0] v;
            v = VEC[i];
            mode = v[16:15];
            addr_load = v[14];
            if (v[11:10] != 2'd0) pulse_cmd(v[11:10]);
            send(v[13], v[12], v[9:2], 1'b0, 1'b0);
            chk($sformatf("R3-8 vec%0d push", i), {7'd0, push}, {7'd0, v[1]});
            chk($sformatf("R5-7 vec%0d rx_en", i), {7'd0, rx_en}, {7'd0, v[0]});
            if (v[1]) begin
                chk($sformatf("R2 vec%0d data", i), push_data, v[9:2]);
                chk($sformatf("R2 vec%0d ad", i), {7'd0, push_ad}, {7'd0, v[13]});
                chk($sformatf("R10 vec%0d brk", i), {7'd0, push_brk}, {7'd0, v[12]});
            end
        end

        // R11: push lasts a single cycle
        mode = 2'b00;
        send(1'b1, 1'b0, 8'h42, 1'b0, 1'b0);
        chk("R11 push on", {7'd0, push}, 8'd1);
        @(posedge clk); #1;
        chk("R11 push off", {7'd0, push}, 8'd0);

        // R9: command coincident with boundary is deferred
        @(negedge clk);
        chr_valid = 1'b1; chr_ad = 1'b0; chr_data = 8'hB0; host_on = 1'b1;
        @(posedge clk); #1;
        chr_valid = 1'b0; host_on = 1'b0;
        chk("R9 same-cycle old state push", {7'd0, push}, 8'd0);
        chk("R9 same-cycle old state en", {7'd0, rx_en}, 8'd0);
        send(1'b0, 1'b0, 8'hB1, 1'b0, 1'b0);
        chk("R9 deferred applied push", {7'd0, push}, 8'd1);
        chk("R9 deferred applied en", {7'd0, rx_en}, 8'd1);

        // R2: framing and overrun flags carried
        send(1'b0, 1'b0, 8'hC3, 1'b1, 1'b1);
        chk("R2 fe", {7'd0, push_fe}, 8'd1);
        chk("R2 ovr", {7'd0, push_ovr}, 8'd1);

        // R9: disable wins over simultaneous enable
        @(negedge clk); host_on = 1'b1; host_off = 1'b1;
        @(posedge clk); #1; host_on = 1'b0; host_off = 1'b0;
        send(1'b0, 1'b0, 8'hD0, 1'b0, 1'b0);
        chk("R9 off wins push", {7'd0, push}, 8'd0);
        chk("R9 off wins en", {7'd0, rx_en}, 8'd0);

        // R9: later command replaces earlier
        pulse_cmd(2'd2);
        pulse_cmd(2'd1);
        send(1'b0, 1'b0, 8'hD1, 1'b0, 1'b0);
        chk("R9 last cmd push", {7'd0, push}, 8'd1);
        chk("R9 last cmd en", {7'd0, rx_en}, 8'd1);

        // R12: transmit A/D register
        @(negedge clk); tx_wr = 1'b1; tx_val = 1'b1;
        @(posedge clk); #1; tx_wr = 1'b0; tx_val = 1'b0;
        chk("R12 tx load", {7'd0, tx_ad}, 8'd1);
        @(posedge clk); #1;
        chk("R12 tx hold", {7'd0, tx_ad}, 8'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule